// File: doc/BRIEF.md
# Instruction-Fetch Execute Permission Check

This block judges one translated instruction fetch per request. Each request carries:

- two access-permission bits from the final translation descriptor: a read-only bit and an unprivileged-access bit;
- the descriptor's unprivileged and privileged execute-never bits;
- the privilege of the fetch;
- a global control bit that makes writable memory non-executable.

One cycle later the block returns a response. The response says whether the fetch may execute. When the fetch is denied, it also carries the exception class and fault status code that the exception logic should record.

Writability can override the descriptor. A region that unprivileged code can write is never executable by a privileged fetch. When the write-implies-no-execute control is set, any region that is writable at the fetching level is also non-executable at that level, even if both execute-never bits in the descriptor are clear. The response also reports whether the region is writable at each privilege level, so that neighbouring logic can use the same decode.

Top module: `xfetch_perm`

## Requirements
- R1: With each response, `wr_priv` is 1 exactly when `ap_ro` was 0. `wr_user` is 1 exactly when `ap_ro` was 0 and `ap_user` was 1.
- R2: With `wxn_en`=0, an unprivileged fetch (`priv`=0) faults exactly when `uxn` is 1. A privileged fetch (`priv`=1) faults exactly when `pxn` is 1, unless the R5 case applies.
- R3: With `wxn_en`=1, an unprivileged fetch faults when `uxn` is 1 or the region is writable at the unprivileged level.
- R4: With `wxn_en`=1, a privileged fetch faults when `pxn` is 1 or `ap_ro` is 0.
- R5: A privileged fetch from a region writable at the unprivileged level (`ap_ro`=0, `ap_user`=1) always faults, whatever the values of `wxn_en` and `pxn`.
- R6: A faulting response has `rsp_fault`=1, `rsp_allow`=0, `rsp_ec`=6'b100001 and `rsp_fsc`=6'b001111.
- R7: An allowed response has `rsp_allow`=1, `rsp_fault`=0, `rsp_ec`=0 and `rsp_fsc`=0.
- R8: `rsp_vld` is 1 in the cycle after a cycle in which `req_vld` was 1, and lasts one cycle for each request. Back-to-back requests each get their own response. In a cycle with `rsp_vld`=0, the outputs `rsp_allow`, `rsp_fault`, `rsp_ec`, `rsp_fsc`, `wr_user` and `wr_priv` are all 0.
- R9: The synchronous reset `rst` clears `rsp_vld`, `rsp_allow` and `rsp_fault`. A request presented while `rst` is 1 produces no response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_vld | input | 1 | A fetch request is present this cycle |
| ap_ro | input | 1 | Descriptor read-only bit (1 = read-only, 0 = read/write) |
| ap_user | input | 1 | Descriptor unprivileged-access bit (1 = unprivileged level has access) |
| uxn | input | 1 | Descriptor unprivileged execute-never bit |
| pxn | input | 1 | Descriptor privileged execute-never bit |
| priv | input | 1 | Fetch privilege (1 = privileged, 0 = unprivileged) |
| wxn_en | input | 1 | Treat writable memory as execute-never |
| rsp_vld | output | 1 | Response valid, one cycle per request |
| rsp_allow | output | 1 | Fetch may execute |
| rsp_fault | output | 1 | Permission fault raised |
| rsp_ec | output | 6 | Exception class on a fault, else 0 |
| rsp_fsc | output | 6 | Fault status code on a fault, else 0 |
| wr_user | output | 1 | Region is writable at the unprivileged level |
| wr_priv | output | 1 | Region is writable at the privileged level |

## Verification
The assertions assume that all request fields are known, 0/1 values in any cycle where `req_vld` is high. They also assume that a response is judged only against the inputs of the cycle before it, so no field needs to stay stable across requests. The stimulus changes inputs only on the falling clock edge. It drives every one of the 64 field combinations as back-to-back requests, and places idle cycles and a request under reset between them. In this way each property sees both its triggering case and its quiet case.

// File: rtl/xfetch_perm.sv
module xfetch_perm #(
  parameter int EC_W = 6,
  parameter int FSC_W = 6,
  parameter logic [EC_W-1:0] EC_IFETCH = 6'b100001,
  parameter logic [FSC_W-1:0] FSC_PERM = 6'b001111
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_vld,
  input  logic             ap_ro,
  input  logic             ap_user,
  input  logic             uxn,
  input  logic             pxn,
  input  logic             priv,
  input  logic             wxn_en,
  output logic             rsp_vld,
  output logic             rsp_allow,
  output logic             rsp_fault,
  output logic [EC_W-1:0]  rsp_ec,
  output logic [FSC_W-1:0] rsp_fsc,
  output logic             wr_user,
  output logic             wr_priv
);

  logic w_priv, w_user, nx_user, nx_priv, deny;

  assign w_priv  = ~ap_ro;
  assign w_user  = ~ap_ro & ap_user;
  assign nx_user = uxn | (wxn_en & w_user);
  assign nx_priv = pxn | w_user | (wxn_en & w_priv);
  assign deny    = priv ? nx_priv : nx_user;

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_vld   <= 1'b0;
      rsp_allow <= 1'b0;
      rsp_fault <= 1'b0;
      rsp_ec    <= '0;
      rsp_fsc   <= '0;
      wr_user   <= 1'b0;
      wr_priv   <= 1'b0;
    end else begin
      rsp_vld   <= req_vld;
      rsp_allow <= req_vld & ~deny;
      rsp_fault <= req_vld & deny;
      rsp_ec    <= (req_vld & deny) ? EC_IFETCH : '0;
      rsp_fsc   <= (req_vld & deny) ? FSC_PERM : '0;
      wr_user   <= req_vld & w_user;
      wr_priv   <= req_vld & w_priv;
    end
  end

  AST_RSP_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (rst) req_vld |=> rsp_vld); // R8
  AST_NO_SPURIOUS_RSP: assert property (@(posedge clk) disable iff (rst) !req_vld |=> !rsp_vld); // R8
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !rsp_vld |-> !rsp_allow && !rsp_fault && rsp_ec == '0 && rsp_fsc == '0); // R8
  AST_ONE_VERDICT: assert property (@(posedge clk) disable iff (rst) rsp_vld |-> $onehot({rsp_allow, rsp_fault})); // R7
  AST_FAULT_CODES: assert property (@(posedge clk) disable iff (rst)
    rsp_fault |-> rsp_ec == EC_IFETCH && rsp_fsc == FSC_PERM); // R6
  AST_ALLOW_CODES: assert property (@(posedge clk) disable iff (rst)
    rsp_allow |-> rsp_ec == '0 && rsp_fsc == '0); // R7
  AST_USER_WR_PRIV_NX: assert property (@(posedge clk) disable iff (rst)
    req_vld && priv && !ap_ro && ap_user |=> rsp_fault); // R5
  AST_WXN_PRIV_NX: assert property (@(posedge clk) disable iff (rst)
    req_vld && priv && wxn_en && !ap_ro |=> rsp_fault); // R4
  AST_WXN_USER_NX: assert property (@(posedge clk) disable iff (rst)
    req_vld && !priv && wxn_en && !ap_ro && ap_user |=> rsp_fault); // R3
  AST_WR_FLAGS: assert property (@(posedge clk) disable iff (rst)
    rsp_vld |-> !wr_user || wr_priv); // R1

endmodule

// File: tb/xfetch_perm_test.sv
`timescale 1ns/1ps
module xfetch_perm_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_vld = 1'b0, ap_ro = 1'b0, ap_user = 1'b0, uxn = 1'b0, pxn = 1'b0, priv = 1'b0, wxn_en = 1'b0;
  logic rsp_vld, rsp_allow, rsp_fault, wr_user, wr_priv;
  logic [5:0] rsp_ec, rsp_fsc;
  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  xfetch_perm uut (
    .clk(clk), .rst(rst), .req_vld(req_vld), .ap_ro(ap_ro), .ap_user(ap_user),
    .uxn(uxn), .pxn(pxn), .priv(priv), .wxn_en(wxn_en),
    .rsp_vld(rsp_vld), .rsp_allow(rsp_allow), .rsp_fault(rsp_fault),
    .rsp_ec(rsp_ec), .rsp_fsc(rsp_fsc), .wr_user(wr_user), .wr_priv(wr_priv)
  );

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic drive(input int v);
    ap_ro = v[0]; ap_user = v[1]; uxn = v[2]; pxn = v[3]; priv = v[4]; wxn_en = v[5];
    req_vld = 1'b1;
  endtask

  task automatic judge(input int v);
    bit ro, us, ux, px, pr, wx, wu, wp, f;
    string rule;
    ro = v[0]; us = v[1]; ux = v[2]; px = v[3]; pr = v[4]; wx = v[5];
    wp = !ro;
    wu = !ro && us;
    if (pr && wu) begin f = 1; rule = "R5"; end
    else if (!wx) begin f = pr ? px : ux; rule = "R2"; end
    else if (pr) begin f = px || wp; rule = "R4"; end
    else begin f = ux || wu; rule = "R3"; end
    chk($sformatf("R8 vld v=%0d", v), rsp_vld, 1);
    chk($sformatf("%s fault v=%0d", rule, v), rsp_fault, f);
    chk($sformatf("R1 wr_user v=%0d", v), wr_user, wu);
    chk($sformatf("R1 wr_priv v=%0d", v), wr_priv, wp);
    if (f) begin
      chk($sformatf("R6 allow v=%0d", v), rsp_allow, 0);
      chk($sformatf("R6 ec v=%0d", v), rsp_ec, 33);
      chk($sformatf("R6 fsc v=%0d", v), rsp_fsc, 15);
    end else begin
      chk($sformatf("R7 allow v=%0d", v), rsp_allow, 1);
      chk($sformatf("R7 ec v=%0d", v), rsp_ec, 0);
      chk($sformatf("R7 fsc v=%0d", v), rsp_fsc, 0);
    end
  endtask

  task automatic quiet(input string tag);
    chk({tag, " vld"}, rsp_vld, 0);
    chk({tag, " allow"}, rsp_allow, 0);
    chk({tag, " fault"}, rsp_fault, 0);
    chk({tag, " codes"}, int'(rsp_ec) + int'(rsp_fsc), 0);
    chk({tag, " wr"}, int'(wr_user) + int'(wr_priv), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    quiet("R9 reset");
    drive(0);
    @(negedge clk);
    quiet("R9 request under reset");
    req_vld = 1'b0;
    rst = 1'b0;
    @(negedge clk);
    quiet("R8 idle after reset");
    for (int v = 0; v < 64; v++) begin
      drive(v);
      @(negedge clk);
      req_vld = 1'b0;
      judge(v);
    end
    @(negedge clk);
    quiet("R8 idle after burst");
    for (int v = 63; v >= 0; v--) begin
      drive(v);
      @(negedge clk);
      req_vld = 1'b0;
      judge(v);
      @(negedge clk);
      quiet("R8 gap");
    end
    drive(17);
    rst = 1'b1;
    @(negedge clk);
    quiet("R9 reset over request");
    rst = 1'b0;
    req_vld = 1'b0;
    @(negedge clk);
    quiet("R9 after reset release");
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule